// File: doc/BRIEF.md
# Dual-Mode Divider Configuration Interface

This block is the programming front end of a frequency synthesizer. It holds the active feedback divider value M (9 bits), the output divider code N (2 bits) and two test-select bits. It presents them, together with a flag that says whether M lies in the range where the loop can lock, to the rest of the synthesizer.

Values arrive by one of two paths. The first is a set of hardwired parallel pins, gated by an active-low load strobe. The second is a three-wire serial port made of a shift clock, a data line and a load line. All pins are brought into one fast system clock through two-flop synchronizers. Edges on the strobe, the serial clock and the serial load line are found in that domain. Every pin change therefore takes effect a fixed two to three system cycles after it happens.

A test output reflects one of four sources picked by the test bits. The parallel path always forces it low.

Top module: `synth_div_cfg`

## Requirements
- R1: While reset is asserted, M and N take the parallel pin values, the test bits and the shift register clear to zero, and the test output is low.
- R2: While the parallel strobe is low, the M and N outputs follow the parallel pins, within a few system cycles.
- R3: The rising edge of the parallel strobe captures M and N. After that, changes on the parallel pins have no effect on M and N.
- R4: With the strobe high, each rising serial-clock edge shifts the data bit into a 14-bit shift register, first bit deepest. The frame order, first bit first, is T1, T0, one null bit, N1, N0, then M8 down to M0. The null bit reaches no output.
- R5: A rising edge on the serial load line (with the strobe high) copies the shift register fields into M, N and the test bits. While the line is low, further serial-clock edges leave M, N and the test bits unchanged.
- R6: While the serial load line is held high, each rising serial-clock edge shifts in one bit and at once updates M, N and the test bits from the shifted contents.
- R7: After a parallel load the test output is low whatever the test bits hold. After a serial load the test bits select the source: 00 gives constant low, 01 gives the shift register's deepest bit (the first bit of the frame), 10 gives the M-divider pulse input, and 11 gives the divided output clock input.
- R8: The lockable flag is high exactly when M is from 10 to 28 inclusive.
- R9: When a parallel strobe rising edge and a serial load rising edge land in the same system cycle, the parallel values win. A later serial load rising edge then replaces them with the shift register contents.
- R10: Driving the strobe low again after a serial load returns M and N to the parallel pin values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pload_n | input | 1 | Parallel load strobe, active low |
| par_m | input | 9 | Parallel M pins |
| par_n | input | 2 | Parallel N pins |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial load line |
| mdiv_pulse | input | 1 | M-divider output pulse, test source |
| fout_clk | input | 1 | Divided output clock, test source |
| m_val | output | 9 | Active M value |
| n_code | output | 2 | Active N code |
| t_bits | output | 2 | Active test bits |
| m_lockable | output | 1 | M within the lockable range |
| test_out | output | 1 | Selected test signal |

## Verification
A wrong shift register shows up only at the next serial load. At that point M, N and the test bits come out with the fields shifted by one slot, for example when the null bit is mishandled. The deepest bit is also visible at once on the test output under select 01. A wrong mode or priority decision shows within three system cycles of the strobe or load edge, as an M value from the wrong path or a test output that is not forced low. Under held-high serial load, each single clock edge has to move every field by exactly one position.

// File: rtl/synth_div_cfg.sv
module synth_div_cfg #(
  parameter int MW       = 9,
  parameter int NW       = 2,
  parameter int TW       = 2,
  parameter int LOCK_MIN = 10,
  parameter int LOCK_MAX = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_load,
  input  logic          mdiv_pulse,
  input  logic          fout_clk,
  output logic [MW-1:0] m_val,
  output logic [NW-1:0] n_code,
  output logic [TW-1:0] t_bits,
  output logic          m_lockable,
  output logic          test_out
);
  localparam int FW = TW + 1 + NW + MW;

  logic [1:0] pl_sy, sl_sy, sc_sy, sd_sy;
  logic [MW-1:0] pm_a, pm_s;
  logic [NW-1:0] pn_a, pn_s;
  logic pl_q, sl_q, sc_q;
  logic [FW-1:0] sr;
  logic par_mode;

  wire pl_s = pl_sy[1];
  wire sl_s = sl_sy[1];
  wire sd_s = sd_sy[1];
  wire pl_rise = pl_s & ~pl_q;
  wire sl_rise = sl_s & ~sl_q;
  wire sc_rise = sc_sy[1] & ~sc_q;
  wire par_evt = ~pl_s | pl_rise;
  wire shift_en = pl_s & sc_rise;
  wire [FW-1:0] sr_nx = {sr[FW-2:0], sd_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pl_sy <= 2'b11; sl_sy <= '0; sc_sy <= '0; sd_sy <= '0;
      pm_a <= '0; pm_s <= '0; pn_a <= '0; pn_s <= '0;
      pl_q <= 1'b1; sl_q <= 1'b0; sc_q <= 1'b0;
    end else begin
      pl_sy <= {pl_sy[0], pload_n};
      sl_sy <= {sl_sy[0], ser_load};
      sc_sy <= {sc_sy[0], ser_clk};
      sd_sy <= {sd_sy[0], ser_dat};
      pm_a <= par_m; pm_s <= pm_a;
      pn_a <= par_n; pn_s <= pn_a;
      pl_q <= pl_s; sl_q <= sl_s; sc_q <= sc_sy[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (shift_en) sr <= sr_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_val <= par_m; n_code <= par_n; t_bits <= '0; par_mode <= 1'b1;
    end else if (par_evt) begin
      m_val <= pm_s; n_code <= pn_s; par_mode <= 1'b1;
    end else if (sl_rise) begin
      m_val <= sr[MW-1:0]; n_code <= sr[MW+NW-1:MW];
      t_bits <= sr[FW-1:FW-TW]; par_mode <= 1'b0;
    end else if (sl_s && shift_en) begin
      m_val <= sr_nx[MW-1:0]; n_code <= sr_nx[MW+NW-1:MW];
      t_bits <= sr_nx[FW-1:FW-TW]; par_mode <= 1'b0;
    end

  assign m_lockable = (m_val >= MW'(LOCK_MIN)) && (m_val <= MW'(LOCK_MAX));

  always_comb
    case (t_bits)
      2'b01:   test_out = ~par_mode & sr[FW-1];
      2'b10:   test_out = ~par_mode & mdiv_pulse;
      2'b11:   test_out = ~par_mode & fout_clk;
      default: test_out = 1'b0;
    endcase

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> (m_val == $past(pm_s)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && pl_q && !sl_rise && !(sl_s && shift_en)) |=> $stable(m_val));
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr[0] == $past(sd_s)));
  a_r5_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_rise && !par_evt) |=> (m_val == $past(sr[MW-1:0])));
  a_r7_par_low: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> !test_out);
  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rise && sl_rise) |=> (m_val == $past(pm_s)));
endmodule

// File: tb/synth_div_cfg_bench.sv
module synth_div_cfg_bench;
  logic clk = 0, rst_n = 0;
  logic pload_n = 0, ser_clk = 0, ser_dat = 0, ser_load = 0;
  logic mdiv_pulse = 0, fout_clk = 0;
  logic [8:0] par_m = 9'd16;
  logic [1:0] par_n = 2'b01;
  logic [8:0] m_val;
  logic [1:0] n_code, t_bits;
  logic m_lockable, test_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  synth_div_cfg u_synth_div_cfg (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .mdiv_pulse(mdiv_pulse), .fout_clk(fout_clk), .m_val(m_val),
    .n_code(n_code), .t_bits(t_bits), .m_lockable(m_lockable), .test_out(test_out));

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; waitc(3);
    ser_clk = 1; waitc(4);
    ser_clk = 0; waitc(3);
  endtask

  task automatic send_frame(input logic [1:0] t, input logic nul, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, nul, n, m};
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic pulse_sload;
    ser_load = 1; waitc(4);
    ser_load = 0; waitc(4);
  endtask

  task automatic t_reset;
    waitc(1);
    chk("R1 m", m_val, 16); chk("R1 n", n_code, 1);
    chk("R1 t", t_bits, 0); chk("R1 test", test_out, 0);
    rst_n = 1; waitc(4);
  endtask

  task automatic t_parallel;
    par_m = 9'd9; par_n = 2'b10; waitc(4);
    chk("R2 m", m_val, 9); chk("R2 n", n_code, 2); chk("R8 m9", m_lockable, 0);
    par_m = 9'd10; waitc(4); chk("R8 m10", m_lockable, 1);
    par_m = 9'd28; waitc(4); chk("R8 m28", m_lockable, 1);
    par_m = 9'd29; waitc(4); chk("R8 m29", m_lockable, 0);
    par_m = 9'd12; waitc(4);
    pload_n = 1; waitc(4);
    par_m = 9'd25; par_n = 2'b11; waitc(4);
    chk("R3 m held", m_val, 12); chk("R3 n held", n_code, 2);
    chk("R7 par low", test_out, 0);
  endtask

  task automatic t_serial;
    send_frame(2'b01, 1'b1, 2'b10, 9'd20);
    chk("R5 m before load", m_val, 12);
    pulse_sload;
    chk("R4 m", m_val, 20); chk("R4 n", n_code, 2); chk("R4 t", t_bits, 1);
    chk("R8 m20", m_lockable, 1);
    chk("R7 sel01", test_out, 0);
    shift_bit(1'b0);
    chk("R7 sel01 deep bit", test_out, 1);
    chk("R5 m stable", m_val, 20); chk("R5 t stable", t_bits, 1);
  endtask

  task automatic t_sel;
    send_frame(2'b10, 1'b0, 2'b00, 9'd14); pulse_sload;
    chk("R4 null ignored t", t_bits, 2);
    mdiv_pulse = 1; waitc(1); chk("R7 sel10 hi", test_out, 1);
    mdiv_pulse = 0; waitc(1); chk("R7 sel10 lo", test_out, 0);
    send_frame(2'b11, 1'b1, 2'b01, 9'd15); pulse_sload;
    fout_clk = 1; waitc(1); chk("R7 sel11", test_out, 1);
    send_frame(2'b00, 1'b1, 2'b01, 9'd15); pulse_sload;
    mdiv_pulse = 1; waitc(1); chk("R7 sel00", test_out, 0);
    mdiv_pulse = 0; fout_clk = 0;
  endtask

  task automatic t_held;
    send_frame(2'b01, 1'b0, 2'b10, 9'd20);
    ser_load = 1; waitc(4);
    chk("R6 initial", m_val, 20);
    shift_bit(1'b1);
    chk("R6 m", m_val, 41); chk("R6 n", n_code, 0); chk("R6 t", t_bits, 2);
    chk("R8 m41", m_lockable, 0);
    ser_load = 0; waitc(4);
  endtask

  task automatic t_priority;
    send_frame(2'b01, 1'b0, 2'b11, 9'd22);
    par_m = 9'd15; par_n = 2'b01;
    pload_n = 0; waitc(4);
    chk("R10 back to par", m_val, 15);
    pload_n = 1; ser_load = 1; waitc(4);
    chk("R9 par wins m", m_val, 15); chk("R9 par wins n", n_code, 1);
    chk("R9 test low", test_out, 0);
    ser_load = 0; waitc(4);
    ser_load = 1; waitc(4);
    chk("R9 serial override m", m_val, 22); chk("R9 serial override n", n_code, 3);
    ser_load = 0; waitc(4);
  endtask

  initial begin
    waitc(3);
    t_reset;
    t_parallel;
    t_serial;
    t_sel;
    t_held;
    t_priority;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule